// File: doc/BRIEF.md
# Bus Controller Auxiliary Command Unit

This block is the register-level core of a byte-wide instrument bus interface. It always acts as system controller and controller-in-charge. A host reaches it through eight write registers and eight read registers, one byte each, selected by a three-bit address.

Writes to the auxiliary register carry two kinds of byte. A byte whose top three bits are zero is an immediate command: power-on, chip reset, send end-of-message, go to standby, take control, set or clear interface clear, set or clear remote enable, or execute parallel poll. Any other byte is a hidden-register load and has no immediate effect. From these commands the core tracks the controller state (idle, active, standby), drives the attention, interface-clear and remote-enable lines, and marks the end-of-message flag on one outgoing byte.

Outgoing and incoming bytes pass through a simple valid/ready stub that stands in for the three-wire bus handshake. Status flags report completed transfers, received end-of-message and service requests to the host, which polls them.

Top module: `gpib_ctl_core`

## Requirements
- R1: After reset the address-status register (read address 4) reads 0x80. Its encoding is bit 7 offline, bit 6 remote enable, bit 5 interface clear, bit 4 end-of-message armed, and bits 1:0 the state (0 idle, 1 active, 2 standby). Status 1 and status 2 read 0x00, and atn, ifc and ren are low.
- R2: Both reset and the chip-reset command (aux byte 0x02) leave the core offline and idle. While offline, every immediate command except power-on (0x00) and chip reset is ignored.
- R3: Set-IFC (0x1E) drives ifc high and clear-IFC (0x16) drives it low. Clearing IFC after it was set, while idle, enters the active state. Take-control is ignored while idle.
- R4: Go-to-standby (0x10) moves the core from active to standby and releases atn. Take-control (0x11) moves it from standby to active and asserts atn. atn changes only on an aux write.
- R5: Set-REN (0x1F) drives ren high and clear-REN (0x17) drives it low.
- R6: Send-EOI (0x06) arms end-of-message. The next accepted data-out write presents its byte with tx_eoi high. The byte after it has tx_eoi low.
- R7: An aux write whose bits 7:5 are not 000 changes none of the command state.
- R8: A write to address 0 in active or standby, with no byte pending, raises tx_valid with the byte. tx_valid and tx_data hold until tx_ready is seen. In standby the write clears status-1 bit 1 (data out), and acceptance sets it. In active the same happens to status-2 bit 3 (command out).
- R9: In standby with data-in clear, rx_ready is high. An accepted byte sets status-1 bit 0 (data in), sets bit 4 (END) when rx_eoi is high, and drops rx_ready. Reading address 0 returns the byte and clears data in.
- R10: Reading status 1 clears data in, data out and END.
- R11: A rising edge on srq sets status-2 bit 6. The next status-2 read reports it and clears it, even while srq stays high.
- R12: A write to address 6 with bit 7 low loads address 0 (read address 6). With bit 7 high it loads address 1 (read address 7). Both read back bits 6:0 with bit 7 zero. Serial-poll mode (write address 3) reads back at read address 3.
- R13: Execute-parallel-poll (0x1D) in the active state captures ppoll_in into the pass-through register (read address 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects) |
| host_addr | input | 3 | Register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| tx_valid | output | 1 | Outgoing byte pending |
| tx_ready | input | 1 | Bus stub accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_eoi | output | 1 | End-of-message with outgoing byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Core can take an incoming byte |
| rx_data | input | 8 | Incoming byte |
| rx_eoi | input | 1 | End-of-message with incoming byte |
| srq | input | 1 | Service request line |
| ppoll_in | input | 8 | Parallel-poll response byte |
| atn | output | 1 | Attention line |
| ifc | output | 1 | Interface clear line |
| ren | output | 1 | Remote enable line |

## Verification
The properties assume that the host and the bus stub behave. The host issues at most one register access per cycle and never a write and a read together. The stub keeps rx_valid low until it samples rx_ready high, and it drives tx_ready only as a single acceptance pulse per pending byte. The stimulus follows these rules. It raises host strobes for exactly one cycle, pulses rx_valid only while rx_ready is high, and returns tx_ready low straight after each acceptance. Service requests are raised as clean level changes and are never toggled within one cycle of a status-2 read.

// File: rtl/gpib_ctl_pkg.sv
package gpib_ctl_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_ACTIVE  = 2'd1,
        CS_STANDBY = 2'd2
    } ctl_state_e;

    // write-side register addresses (order is decoded by the host)
    localparam logic [REG_AW-1:0] WA_DOUT  = 3'd0;
    localparam logic [REG_AW-1:0] WA_SPOLL = 3'd3;
    localparam logic [REG_AW-1:0] WA_AUX   = 3'd5;
    localparam logic [REG_AW-1:0] WA_ADDR  = 3'd6;

    // read-side register addresses
    localparam logic [REG_AW-1:0] RA_DIN   = 3'd0;
    localparam logic [REG_AW-1:0] RA_STAT1 = 3'd1;
    localparam logic [REG_AW-1:0] RA_STAT2 = 3'd2;
    localparam logic [REG_AW-1:0] RA_SPOLL = 3'd3;
    localparam logic [REG_AW-1:0] RA_ASTAT = 3'd4;
    localparam logic [REG_AW-1:0] RA_PASS  = 3'd5;
    localparam logic [REG_AW-1:0] RA_ADR0  = 3'd6;
    localparam logic [REG_AW-1:0] RA_ADR1  = 3'd7;

    // immediate command codes (low five bits, top three bits zero)
    localparam logic [4:0] IC_POWER_ON = 5'h00;
    localparam logic [4:0] IC_CHIP_RST = 5'h02;
    localparam logic [4:0] IC_ARM_EOI  = 5'h06;
    localparam logic [4:0] IC_STANDBY  = 5'h10;
    localparam logic [4:0] IC_TAKE_CTL = 5'h11;
    localparam logic [4:0] IC_IFC_OFF  = 5'h16;
    localparam logic [4:0] IC_REN_OFF  = 5'h17;
    localparam logic [4:0] IC_PPOLL    = 5'h1D;
    localparam logic [4:0] IC_IFC_ON   = 5'h1E;
    localparam logic [4:0] IC_REN_ON   = 5'h1F;

    typedef struct packed {
        logic power_on;
        logic chip_rst;
        logic arm_eoi;
        logic standby;
        logic take_ctl;
        logic ifc_off;
        logic ren_off;
        logic ppoll;
        logic ifc_on;
        logic ren_on;
    } aux_req_t;

    function automatic aux_req_t decode_aux(input logic [BYTE_W-1:0] b);
        aux_req_t r;
        logic     imm;
        imm        = (b[7:5] == 3'b000);
        r.power_on = imm && (b[4:0] == IC_POWER_ON);
        r.chip_rst = imm && (b[4:0] == IC_CHIP_RST);
        r.arm_eoi  = imm && (b[4:0] == IC_ARM_EOI);
        r.standby  = imm && (b[4:0] == IC_STANDBY);
        r.take_ctl = imm && (b[4:0] == IC_TAKE_CTL);
        r.ifc_off  = imm && (b[4:0] == IC_IFC_OFF);
        r.ren_off  = imm && (b[4:0] == IC_REN_OFF);
        r.ppoll    = imm && (b[4:0] == IC_PPOLL);
        r.ifc_on   = imm && (b[4:0] == IC_IFC_ON);
        r.ren_on   = imm && (b[4:0] == IC_REN_ON);
        return r;
    endfunction

endpackage

// File: rtl/gpib_aux_decode.sv
module gpib_aux_decode
    import gpib_ctl_pkg::*;
(
    input  logic              aux_wr,
    input  logic [BYTE_W-1:0] aux_byte,
    output aux_req_t          req
);
    aux_req_t dec;

    always_comb begin
        dec = decode_aux(aux_byte);
        req = aux_wr ? dec : '0;
    end
endmodule

// File: rtl/gpib_ctl_fsm.sv
module gpib_ctl_fsm
    import gpib_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  aux_req_t   req,
    input  logic       dout_take,
    output ctl_state_e state,
    output logic       offline,
    output logic       ifc_q,
    output logic       ren_q,
    output logic       eoi_arm,
    output logic       ppoll_go
);
    assign ppoll_go = req.ppoll && !offline && (state == CS_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst || req.chip_rst) begin
            offline <= 1'b1;
            state   <= CS_IDLE;
            ifc_q   <= 1'b0;
            ren_q   <= 1'b0;
            eoi_arm <= 1'b0;
        end else if (offline) begin
            if (req.power_on) offline <= 1'b0;
        end else begin
            if (req.ifc_on) ifc_q <= 1'b1;
            if (req.ifc_off) begin
                ifc_q <= 1'b0;
                if (ifc_q && state == CS_IDLE) state <= CS_ACTIVE;
            end
            if (req.take_ctl && state == CS_STANDBY) state <= CS_ACTIVE;
            if (req.standby && state == CS_ACTIVE)   state <= CS_STANDBY;
            if (req.ren_on)  ren_q <= 1'b1;
            if (req.ren_off) ren_q <= 1'b0;
            if (req.arm_eoi)     eoi_arm <= 1'b1;
            else if (dout_take)  eoi_arm <= 1'b0;
        end
    end
endmodule

// File: rtl/gpib_io_flags.sv
module gpib_io_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         dout_take,
    input  logic [W-1:0] dout_byte,
    input  logic         dout_eoi,
    input  logic         dout_cmd,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data,
    output logic         tx_eoi,
    input  logic         rx_en,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_eoi,
    output logic         rx_ready,
    output logic [W-1:0] rx_byte,
    input  logic         rd_stat1,
    input  logic         rd_stat2,
    input  logic         rd_din,
    input  logic         srq,
    output logic         f_din,
    output logic         f_dout,
    output logic         f_end,
    output logic         f_cout,
    output logic         f_srq
);
    logic tx_cmd;
    logic srq_q;

    assign rx_ready = rx_en && !f_din;

    always_ff @(posedge clk) begin
        if (rst) srq_q <= srq;
        else     srq_q <= srq;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_eoi   <= 1'b0;
            tx_cmd   <= 1'b0;
            rx_byte  <= '0;
            f_din    <= 1'b0;
            f_dout   <= 1'b0;
            f_end    <= 1'b0;
            f_cout   <= 1'b0;
            f_srq    <= 1'b0;
        end else begin
            if (rd_stat1) begin
                f_din  <= 1'b0;
                f_dout <= 1'b0;
                f_end  <= 1'b0;
            end
            if (rd_din)   f_din <= 1'b0;
            if (rd_stat2) f_srq <= 1'b0;
            if (srq && !srq_q) f_srq <= 1'b1;

            if (tx_valid && tx_ready) begin
                tx_valid <= 1'b0;
                tx_eoi   <= 1'b0;
                if (tx_cmd) f_cout <= 1'b1;
                else        f_dout <= 1'b1;
            end else if (dout_take) begin
                tx_valid <= 1'b1;
                tx_data  <= dout_byte;
                tx_eoi   <= dout_eoi;
                tx_cmd   <= dout_cmd;
                if (dout_cmd) f_cout <= 1'b0;
                else          f_dout <= 1'b0;
            end

            if (rx_valid && rx_ready) begin
                rx_byte <= rx_data;
                f_din   <= 1'b1;
                if (rx_eoi) f_end <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpib_ctl_core.sv
module gpib_ctl_core
    import gpib_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_eoi,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_eoi,
    input  logic        srq,
    input  logic [7:0]  ppoll_in,
    output logic        atn,
    output logic        ifc,
    output logic        ren
);
    localparam int AW = BYTE_W - 1;

    aux_req_t          req;
    ctl_state_e        state;
    logic              offline, eoi_arm, ppoll_go, dout_take;
    logic              f_din, f_dout, f_end, f_cout, f_srq;
    logic [BYTE_W-1:0] rx_byte, spoll_q, pass_q;
    logic [AW-1:0]     adr0_q, adr1_q;

    gpib_aux_decode u_dec (
        .aux_wr   (host_wr && host_addr == WA_AUX),
        .aux_byte (host_wdata),
        .req      (req)
    );

    assign dout_take = host_wr && (host_addr == WA_DOUT) && !offline &&
                       (state != CS_IDLE) && !tx_valid;

    gpib_ctl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .dout_take (dout_take),
        .state     (state),
        .offline   (offline),
        .ifc_q     (ifc),
        .ren_q     (ren),
        .eoi_arm   (eoi_arm),
        .ppoll_go  (ppoll_go)
    );

    assign atn = (state == CS_ACTIVE);

    gpib_io_flags #(.W(BYTE_W)) u_io (
        .clk       (clk),
        .rst       (rst),
        .flush     (req.chip_rst),
        .dout_take (dout_take),
        .dout_byte (host_wdata),
        .dout_eoi  (eoi_arm),
        .dout_cmd  (atn),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_eoi    (tx_eoi),
        .rx_en     (!offline && state == CS_STANDBY),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eoi    (rx_eoi),
        .rx_ready  (rx_ready),
        .rx_byte   (rx_byte),
        .rd_stat1  (host_rd && host_addr == RA_STAT1),
        .rd_stat2  (host_rd && host_addr == RA_STAT2),
        .rd_din    (host_rd && host_addr == RA_DIN),
        .srq       (srq),
        .f_din     (f_din),
        .f_dout    (f_dout),
        .f_end     (f_end),
        .f_cout    (f_cout),
        .f_srq     (f_srq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spoll_q <= '0;
            pass_q  <= '0;
            adr0_q  <= '0;
            adr1_q  <= '0;
        end else begin
            if (host_wr && host_addr == WA_SPOLL) spoll_q <= host_wdata;
            if (host_wr && host_addr == WA_ADDR) begin
                if (host_wdata[BYTE_W-1]) adr1_q <= host_wdata[AW-1:0];
                else                      adr0_q <= host_wdata[AW-1:0];
            end
            if (ppoll_go) pass_q <= ppoll_in;
        end
    end

    always_comb begin
        unique case (host_addr)
            RA_DIN:   host_rdata = rx_byte;
            RA_STAT1: host_rdata = {3'b000, f_end, 2'b00, f_dout, f_din};
            RA_STAT2: host_rdata = {1'b0, f_srq, 2'b00, f_cout, 3'b000};
            RA_SPOLL: host_rdata = spoll_q;
            RA_ASTAT: host_rdata = {offline, ren, ifc, eoi_arm, 2'b00, state};
            RA_PASS:  host_rdata = pass_q;
            RA_ADR0:  host_rdata = {1'b0, adr0_q};
            default:  host_rdata = {1'b0, adr1_q};
        endcase
    end
endmodule

// File: rtl/gpib_ctl_chk.sv
module gpib_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic [2:0] host_addr,
    input logic [7:0] host_rdata,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_eoi,
    input logic       rx_ready,
    input logic       atn,
    input logic       ifc,
    input logic       ren
);
    // R6: end-of-message never shows without a byte
    p_eoi_with_byte_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> !tx_eoi);

    // R8: pending byte held until accepted (chip reset may flush it)
    p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !(host_wr && host_addr == 3'd5)
        |=> tx_valid && $stable(tx_data));

    // R8: a new byte only follows a data-out write
    p_tx_origin_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(host_wr && host_addr == 3'd0));

    // R4: attention moves only after an aux write
    p_atn_by_aux_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(atn) |-> $past(host_wr && host_addr == 3'd5));

    // R9: receive path is only open with attention released
    p_rx_not_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !atn);

    // R2: an offline core drives no bus control line
    p_offline_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_addr == 3'd4 && host_rdata[7] |-> !atn && !ifc && !ren);
endmodule

bind gpib_ctl_core gpib_ctl_chk u_chk (.*);

// File: tb/gpib_ctl_core_test.sv
module gpib_ctl_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_valid, tx_eoi, rx_ready, atn, ifc, ren;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0, rx_valid = 1'b0, rx_eoi = 1'b0, srq = 1'b0;
    logic [7:0] rx_data = '0, ppoll_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpib_ctl_core uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_eoi(tx_eoi),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_eoi(rx_eoi),
        .srq(srq), .ppoll_in(ppoll_in), .atn(atn), .ifc(ifc), .ren(ren)
    );

    // {req id, is_wr, addr, data, expected read}
    localparam int NV = 30;
    localparam logic [23:0] VEC [NV] = '{
        24'h1_4_00_80, 24'h1_1_00_00, 24'h1_2_00_00,  // R1 reset values
        24'h2_D_1F_00, 24'h2_4_00_80,                 // R2 REN ignored offline
        24'h2_D_00_00, 24'h2_4_00_00,                 // R2 power-on
        24'h3_D_11_00, 24'h3_4_00_00,                 // R3 take-control in idle ignored
        24'h3_D_1E_00, 24'h3_4_00_20,                 // R3 IFC on
        24'h3_D_16_00, 24'h3_4_00_01,                 // R3 IFC off -> active
        24'h5_D_1F_00, 24'h5_4_00_41,                 // R5 REN on
        24'h4_D_10_00, 24'h4_4_00_42,                 // R4 standby
        24'h4_D_11_00, 24'h4_4_00_41,                 // R4 take control
        24'h7_D_26_00, 24'h7_4_00_41,                 // R7 hidden load
        24'h7_D_70_00, 24'h7_4_00_41,                 // R7 hidden load
        24'h5_D_17_00, 24'h5_4_00_01,                 // R5 REN off
        24'hC_E_6A_00, 24'hC_E_83_00,                 // R12 address loads
        24'hC_6_00_6A, 24'hC_7_00_03,                 // R12 readback
        24'hC_B_41_00                                  // R12 serial-poll mode
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_ready();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 atn/ifc/ren", {5'b0, atn, ifc, ren}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                do_rd(VEC[i][18:16], v);
                check($sformatf("R%0d table %0d", VEC[i][23:20], i), v, VEC[i][7:0]);
            end
        end
        do_rd(3'd3, v); check("R12 serial poll", v, 8'h41);

        // R4 port level in active
        check("R4 atn active", {7'b0, atn}, 8'h01);
        check("R5 ren off", {7'b0, ren}, 8'h00);

        // R8 command byte in active
        do_wr(3'd0, 8'h3F);
        check("R8 tx_valid", {7'b0, tx_valid}, 8'h01);
        check("R8 tx_data", tx_data, 8'h3F);
        do_rd(3'd2, v); check("R8 command-out cleared", v, 8'h00);
        repeat (3) @(negedge clk);
        check("R8 held", {7'b0, tx_valid}, 8'h01);
        pulse_ready();
        check("R8 accepted", {7'b0, tx_valid}, 8'h00);
        do_rd(3'd2, v); check("R8 command-out set", v, 8'h08);

        // R6 end-of-message on one data byte
        do_wr(3'd5, 8'h10);
        check("R4 atn standby", {7'b0, atn}, 8'h00);
        do_wr(3'd5, 8'h06);
        do_rd(3'd4, v); check("R6 armed", v, 8'h12);
        do_wr(3'd0, 8'h55);
        check("R6 eoi with byte", {7'b0, tx_eoi}, 8'h01);
        check("R6 data", tx_data, 8'h55);
        do_rd(3'd4, v); check("R6 disarmed", v, 8'h02);
        pulse_ready();
        do_rd(3'd1, v); check("R8 data-out set", v, 8'h02);
        do_rd(3'd1, v); check("R10 status1 cleared", v, 8'h00);
        do_wr(3'd0, 8'h56);
        check("R6 no eoi next", {7'b0, tx_eoi}, 8'h00);
        pulse_ready();

        // R9 receive
        check("R9 rx_ready", {7'b0, rx_ready}, 8'h01);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h0A; rx_eoi = 1'b1;
        @(negedge clk); rx_valid = 1'b0; rx_eoi = 1'b0;
        check("R9 rx_ready low", {7'b0, rx_ready}, 8'h00);
        do_rd(3'd0, v); check("R9 data in", v, 8'h0A);
        check("R9 rx_ready back", {7'b0, rx_ready}, 8'h01);
        do_rd(3'd1, v); check("R10 END and data-out", v, 8'h12);
        do_rd(3'd1, v); check("R10 cleared again", v, 8'h00);

        // R11 service request reported once
        @(negedge clk); srq = 1'b1;
        repeat (2) @(negedge clk);
        do_rd(3'd2, v); check("R11 srq set", v, 8'h48);
        do_rd(3'd2, v); check("R11 srq once", v, 8'h08);

        // R13 parallel poll
        ppoll_in = 8'hC3;
        do_wr(3'd5, 8'h11);
        do_wr(3'd5, 8'h1D);
        do_rd(3'd5, v); check("R13 pass-through", v, 8'hC3);

        // R2 chip reset
        do_wr(3'd5, 8'h02);
        do_rd(3'd4, v); check("R2 chip reset offline", v, 8'h80);
        check("R2 atn low", {7'b0, atn}, 8'h00);
        do_wr(3'd5, 8'h1E);
        check("R2 ifc ignored", {7'b0, ifc}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule